// File: doc/BRIEF.md
# Per-Stream Time Gate Policer

This block sits at ingress, ahead of a time-scheduled egress stage, and decides for every incoming frame descriptor whether the frame may continue. Each descriptor carries a stream number and a byte length. The stream number selects two things: a cyclic gate pattern and a token bucket. A frame continues only if both allow it. The gate must be open at the frame's arrival time, and the stream's bucket must hold enough credit for the frame's length.

The gate pattern repeats once every hyperperiod of a shared time base. The block tracks the position within the hyperperiod with a wrapping phase register that adds each cycle's time advance. It does not use a divider. Every stream has up to four entries per hyperperiod. Each entry has an ascending end phase and an open flag.

Credit comes back in fixed ticks and is capped at a burst size for each stream. The block keeps two saturating drop counters per stream: one for frames refused by a closed gate, one for frames refused for lack of credit.

Top module: `stream_gate_policer`

## Requirements
- R1: During and straight after reset, `pass_valid_o` and `pass_o` are 0. Every drop counter is 0 and every bucket holds 0 tokens.
- R2: A frame that arrives while its stream's gate is closed is dropped. It adds one to that stream's gate-drop counter and consumes no tokens.
- R3: A frame that arrives with its gate open, while its stream's bucket holds at least `frame_len_i` tokens, passes (`pass_o`=1). Its length is subtracted from the bucket.
- R4: A frame that arrives with its gate open, while the bucket holds fewer tokens than its length, is dropped. It adds one to the rate-drop counter and leaves the bucket unchanged.
- R5: The gate phase equals `time_i` modulo `hyper_i`. The active entry is the lowest index k with phase < end[k], and the gate state is that entry's open bit (1 = open). A phase at or past the last end is closed.
- R6: Once every TICK_CYCLES clocks (the first tick falls on clock TICK_CYCLES after reset), every bucket becomes min(burst, tokens after this cycle's deduction + rate).
- R7: Both drop counters saturate at 2^CNT_W-1. They never wrap.
- R8: A decision appears one clock after the descriptor. `pass_valid_o` follows `frame_valid_i` by exactly one cycle. Counter updates appear on the same edge.
- R9: A frame affects only the bucket and the counters of its own stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| time_i | input | TIME_W | Shared time base |
| hyper_i | input | TIME_W | Hyperperiod length in time units |
| cfg_gate_end_i | input | N_STREAMS*N_ENT*TIME_W | End phase of each gate entry per stream, ascending |
| cfg_gate_open_i | input | N_STREAMS*N_ENT | Open flag of each gate entry per stream |
| cfg_rate_i | input | N_STREAMS*TOK_W | Tokens added per tick per stream |
| cfg_burst_i | input | N_STREAMS*TOK_W | Bucket cap per stream |
| frame_valid_i | input | 1 | Descriptor present |
| frame_sid_i | input | SID_W | Stream number |
| frame_len_i | input | LEN_W | Frame length in bytes |
| pass_valid_o | output | 1 | Decision present |
| pass_o | output | 1 | 1 = frame forwarded, 0 = dropped |
| gate_drop_cnt_o | output | N_STREAMS*CNT_W | Gate-closed drops per stream |
| rate_drop_cnt_o | output | N_STREAMS*CNT_W | Credit drops per stream |

## Verification
The phase assertion assumes three things about the inputs: `hyper_i` is nonzero and constant, `time_i` advances by less than one hyperperiod per clock, and `time_i` starts below `hyper_i` when reset ends. The stimulus holds the hyperperiod at 100. It starts time at zero and advances it by 1 to 3 per clock, with an occasional jump of 97.

The bucket cap assertion assumes the configured rate and burst stay constant. The bench never changes them after reset. The gate entries are programmed in ascending order, and the last end is below the hyperperiod, so the closed tail after the last entry is exercised.

// File: rtl/gpol_pkg.sv
package gpol_pkg;
  typedef enum logic [1:0] {
    VERD_PASS = 2'd0,
    VERD_GATE = 2'd1,
    VERD_RATE = 2'd2
  } verdict_e;
endpackage

// File: rtl/gpol_phase.sv
module gpol_phase #(
  parameter int TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] hyper_i,
  output logic [TIME_W-1:0] phase_o
);
  logic [TIME_W-1:0] phase_q, time_q, delta;
  logic [TIME_W:0]   sum, wrap;

  // phase advances by the time step, one subtraction keeps it below hyper
  always_comb begin
    delta   = time_i - time_q;
    sum     = {1'b0, phase_q} + {1'b0, delta};
    wrap    = sum - {1'b0, hyper_i};
    phase_o = (sum >= {1'b0, hyper_i}) ? wrap[TIME_W-1:0] : sum[TIME_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      time_q  <= '0;
    end else begin
      phase_q <= phase_o;
      time_q  <= time_i;
    end
  end

  assert_phase_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < hyper_i);
endmodule

// File: rtl/gpol_gate.sv
module gpol_gate #(
  parameter int TIME_W = 32,
  parameter int N_ENT  = 4
) (
  input  logic [TIME_W-1:0]            phase_i,
  input  logic [N_ENT-1:0][TIME_W-1:0] end_i,
  input  logic [N_ENT-1:0]             open_i,
  output logic                         open_o
);
  logic hit;

  always_comb begin
    hit    = 1'b0;
    open_o = 1'b0;
    for (int k = 0; k < N_ENT; k++) begin
      if (!hit && (phase_i < end_i[k])) begin
        hit    = 1'b1;
        open_o = open_i[k];
      end
    end
  end
endmodule

// File: rtl/gpol_bucket.sv
module gpol_bucket #(
  parameter int TOK_W = 16,
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             take_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [TOK_W-1:0] rate_i,
  input  logic [TOK_W-1:0] burst_i,
  output logic             ok_o
);
  logic [TOK_W-1:0] tok_q, tok_d, len_ext, after;
  logic [TOK_W:0]   fill;

  always_comb begin
    len_ext = TOK_W'(len_i);
    ok_o    = tok_q >= len_ext;
    after   = (take_i && ok_o) ? tok_q - len_ext : tok_q;
    fill    = {1'b0, after} + {1'b0, rate_i};
    if (!tick_i)                     tok_d = after;
    else if (fill > {1'b0, burst_i}) tok_d = burst_i;
    else                             tok_d = fill[TOK_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tok_q <= '0;
    else         tok_q <= tok_d;
  end

  assert_refill_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> tok_q <= $past(burst_i));
  assert_no_growth_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> tok_q <= $past(tok_q));
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !take_i) |=> $stable(tok_q));
endmodule

// File: rtl/gpol_cnt.sv
module gpol_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && ~&cnt_o)     cnt_o <= cnt_o + 1'b1;
  end

  assert_cnt_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));
  assert_cnt_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_o) |=> (&cnt_o));
endmodule

// File: rtl/stream_gate_policer.sv
module stream_gate_policer
  import gpol_pkg::*;
#(
  parameter int N_STREAMS   = 16,
  parameter int N_ENT       = 4,
  parameter int TIME_W      = 32,
  parameter int LEN_W       = 11,
  parameter int TOK_W       = 16,
  parameter int CNT_W       = 16,
  parameter int TICK_CYCLES = 8,
  localparam int SID_W      = $clog2(N_STREAMS),
  localparam int TICK_W     = $clog2(TICK_CYCLES + 1)
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic [TIME_W-1:0]                         time_i,
  input  logic [TIME_W-1:0]                         hyper_i,
  input  logic [N_STREAMS-1:0][N_ENT-1:0][TIME_W-1:0] cfg_gate_end_i,
  input  logic [N_STREAMS-1:0][N_ENT-1:0]           cfg_gate_open_i,
  input  logic [N_STREAMS-1:0][TOK_W-1:0]           cfg_rate_i,
  input  logic [N_STREAMS-1:0][TOK_W-1:0]           cfg_burst_i,
  input  logic                                      frame_valid_i,
  input  logic [SID_W-1:0]                          frame_sid_i,
  input  logic [LEN_W-1:0]                          frame_len_i,
  output logic                                      pass_valid_o,
  output logic                                      pass_o,
  output logic [N_STREAMS-1:0][CNT_W-1:0]           gate_drop_cnt_o,
  output logic [N_STREAMS-1:0][CNT_W-1:0]           rate_drop_cnt_o
);
  logic [TIME_W-1:0]    phase;
  logic                 gate_open;
  logic [TICK_W-1:0]    tick_q;
  logic                 tick;
  logic [N_STREAMS-1:0] take, ok, inc_gate, inc_rate;
  verdict_e             verd;

  gpol_phase #(.TIME_W(TIME_W)) u_phase (
    .clk_i, .rst_ni, .time_i, .hyper_i, .phase_o(phase)
  );

  gpol_gate #(.TIME_W(TIME_W), .N_ENT(N_ENT)) u_gate (
    .phase_i(phase),
    .end_i  (cfg_gate_end_i[frame_sid_i]),
    .open_i (cfg_gate_open_i[frame_sid_i]),
    .open_o (gate_open)
  );

  assign tick = (tick_q == TICK_W'(TICK_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tick_q <= '0;
    else if (tick) tick_q <= '0;
    else           tick_q <= tick_q + 1'b1;
  end

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_stream
    logic sel;
    assign sel         = frame_valid_i && (frame_sid_i == SID_W'(s));
    assign take[s]     = sel && gate_open;
    assign inc_gate[s] = sel && !gate_open;
    assign inc_rate[s] = take[s] && !ok[s];

    gpol_bucket #(.TOK_W(TOK_W), .LEN_W(LEN_W)) u_bucket (
      .clk_i, .rst_ni, .tick_i(tick), .take_i(take[s]), .len_i(frame_len_i),
      .rate_i(cfg_rate_i[s]), .burst_i(cfg_burst_i[s]), .ok_o(ok[s])
    );
    gpol_cnt #(.CNT_W(CNT_W)) u_gate_cnt (
      .clk_i, .rst_ni, .inc_i(inc_gate[s]), .cnt_o(gate_drop_cnt_o[s])
    );
    gpol_cnt #(.CNT_W(CNT_W)) u_rate_cnt (
      .clk_i, .rst_ni, .inc_i(inc_rate[s]), .cnt_o(rate_drop_cnt_o[s])
    );
  end

  always_comb begin
    if (!gate_open)          verd = VERD_GATE;
    else if (ok[frame_sid_i]) verd = VERD_PASS;
    else                     verd = VERD_RATE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_valid_o <= 1'b0;
      pass_o       <= 1'b0;
    end else begin
      pass_valid_o <= frame_valid_i;
      pass_o       <= frame_valid_i && (verd == VERD_PASS);
    end
  end

  assert_valid_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |=> pass_valid_o);
  assert_no_idle_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> !pass_valid_o);
  assert_pass_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> pass_valid_o);
  assert_one_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|inc_gate, |inc_rate}));
endmodule

// File: tb/stream_gate_policer_bench.sv
module stream_gate_policer_bench;
  localparam int NS = 16, NE = 4, TW = 32, LW = 11, KW = 12, CW = 6, TICK = 8;
  localparam int HYP = 100;

  logic clk = 0, rst_n = 0;
  logic [TW-1:0] tm = '0;
  logic [NS-1:0][NE-1:0][TW-1:0] c_end;
  logic [NS-1:0][NE-1:0] c_open;
  logic [NS-1:0][KW-1:0] c_rate, c_burst;
  logic fv = 0;
  logic [3:0] fsid = '0;
  logic [LW-1:0] flen = '0;
  logic pv, ps;
  logic [NS-1:0][CW-1:0] gcnt_o, rcnt_o;

  always #5 clk = ~clk;

  stream_gate_policer #(.N_STREAMS(NS), .N_ENT(NE), .TIME_W(TW), .LEN_W(LW),
    .TOK_W(KW), .CNT_W(CW), .TICK_CYCLES(TICK)) u_stream_gate_policer (
    .clk_i(clk), .rst_ni(rst_n), .time_i(tm), .hyper_i(TW'(HYP)),
    .cfg_gate_end_i(c_end), .cfg_gate_open_i(c_open), .cfg_rate_i(c_rate),
    .cfg_burst_i(c_burst), .frame_valid_i(fv), .frame_sid_i(fsid),
    .frame_len_i(flen), .pass_valid_o(pv), .pass_o(ps),
    .gate_drop_cnt_o(gcnt_o), .rate_drop_cnt_o(rcnt_o));

  int checks = 0, failures = 0;
  int tok[NS], mg[NS], mr[NS];
  int tickc = 0;
  int cmax = (1 << CW) - 1;
  bit ev = 0, ep = 0;
  int er = 0; // 0 pass, 1 gate, 2 rate

  // behavioural reference, evaluated on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin tok[s] = 0; mg[s] = 0; mr[s] = 0; end
      tickc = 0; ev = 0; ep = 0; er = 0;
    end else begin
      bit tk, op, hit;
      int ph, sid;
      tk = (tickc == TICK - 1);
      tickc = tk ? 0 : tickc + 1;
      ev = fv; ep = 0;
      if (fv) begin
        sid = int'(fsid);
        ph = int'(tm) % HYP;
        op = 0; hit = 0;
        for (int k = 0; k < NE; k++)
          if (!hit && ph < int'(c_end[sid][k])) begin hit = 1; op = c_open[sid][k]; end
        if (!op) begin er = 1; if (mg[sid] < cmax) mg[sid]++; end
        else if (tok[sid] >= int'(flen)) begin er = 0; ep = 1; tok[sid] -= int'(flen); end
        else begin er = 2; if (mr[sid] < cmax) mr[sid]++; end
      end
      if (tk)
        for (int s = 0; s < NS; s++) begin
          tok[s] += int'(c_rate[s]);
          if (tok[s] > int'(c_burst[s])) tok[s] = int'(c_burst[s]);
        end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (pv !== ev) begin
        failures++; $display("FAIL R8 pass_valid actual=%0b expected=%0b", pv, ev);
      end
      if (ev) begin
        checks++;
        if (ps !== ep) begin
          failures++;
          case (er)
            1: $display("FAIL R2 R5 gate verdict actual=%0b expected=%0b", ps, ep);
            2: $display("FAIL R4 R6 rate verdict actual=%0b expected=%0b", ps, ep);
            default: $display("FAIL R3 R6 pass verdict actual=%0b expected=%0b", ps, ep);
          endcase
        end
      end
      for (int s = 0; s < NS; s++) begin
        checks += 2;
        if (int'(gcnt_o[s]) != mg[s]) begin
          failures++; $display("FAIL R7 R9 gate_cnt[%0d] actual=%0d expected=%0d", s, gcnt_o[s], mg[s]);
        end
        if (int'(rcnt_o[s]) != mr[s]) begin
          failures++; $display("FAIL R7 R9 rate_cnt[%0d] actual=%0d expected=%0d", s, rcnt_o[s], mr[s]);
        end
      end
    end
  end

  task automatic advance();
    if ($urandom % 20 == 0) tm = tm + 97;
    else                    tm = tm + TW'(1 + $urandom % 3);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      c_end[s][0] = TW'(10 + s);
      c_end[s][1] = TW'(40);
      c_end[s][2] = TW'(70);
      c_end[s][3] = TW'(90);
      c_open[s]   = 4'(s) ^ 4'b0101;
      c_rate[s]   = KW'(2 + s);
      c_burst[s]  = KW'(30 + 8 * s);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (pv !== 1'b0 || ps !== 1'b0 || gcnt_o != '0 || rcnt_o != '0) begin
      failures++; $display("FAIL R1 reset outputs actual=%0b%0b expected=00", pv, ps);
    end
    rst_n = 1;
    // R4 with empty buckets: first frame on an open stream hits an empty bucket
    @(negedge clk); fv = 1; fsid = 4'd10; flen = 11'd5; advance();
    @(negedge clk); fv = 0; advance();
    // let buckets fill, then mixed traffic (R2 R3 R5 R6 R9)
    for (int c = 0; c < 60; c++) begin @(negedge clk); advance(); end
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      advance();
      fv   = ($urandom % 2) == 0;
      fsid = 4'($urandom % NS);
      flen = LW'(1 + $urandom % 48);
    end
    @(negedge clk); fv = 0;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule